// File: doc/BRIEF.md
# Ring-Oscillator Phase Encoder

This block turns latched snapshots of a 15-stage inverting ring oscillator, together with two coarse cycle counters, into compact binary timestamps. Each event carries three records taken from the same shared oscillator: arrival, over-threshold and calibration. All three are decoded in parallel. Both edge polarities of every stage count, so one oscillator period holds 30 equally weighted bins. With the nominal bin of about 29 ps, a 12-bit code covers the 50 ns range.

The latch logic raises `done` for one clock while the three 37-bit records are stable on `snapIn`. One clock later the block presents the 111-bit raw word and the 36-bit encoded word, and pulses `wordValid` for the serializers. Coarse-count ambiguity at the wrap point is resolved with two counters: one advances on the rising edge of stage 0 and the other on its falling edge. The block reads whichever counter has its edge farthest from the latched phase. Phase snapshots that show more than one pattern break are flagged, and a code is still produced from them.

Top module: `phaseStampEncoder`

## Requirements
- R1: While `rstN` is low and after it is released, and until the first `done`, `wordValid`, `rawWord`, `codeWord` and `bubbleErr` are all zero.
- R2: A record is 37 bits. Bits [14:0] are the phase of stages 0..14. Bits [25:15] are the counter that advances on each rising edge of stage 0. Bits [36:26] are the counter that advances on each falling edge of stage 0. `snapIn` holds arrival in [36:0], over-threshold in [73:37] and calibration in [110:74]. `rawWord` equals the `snapIn` sampled with `done`.
- R3: `wordValid` is high for exactly the one cycle after each `done` cycle. `rawWord`, `codeWord` and `bubbleErr` change only in that cycle.
- R4: A break at position j (j=1..14) means phase[j-1]==phase[j]. A break at position 0 means phase[14]==phase[0]. The fine value uses the lowest break position p. It is p+15 when phase[0] XOR (p!=0) is 1, and p otherwise, which gives a range of 0..29.
- R5: The coarse value is taken from the rising-edge counter minus 1 when fine is in 8..22. It is the falling-edge counter minus 1 when fine is in 23..29, and the falling-edge counter when fine is in 0..7. The other counter has no effect.
- R6: Each 12-bit code is (coarse*30 + fine) mod 4096. `codeWord` holds arrival in [11:0], over-threshold in [23:12] and calibration in [35:24].
- R7: When `relMode` is 1 at `done`, the over-threshold field is (overThreshold − arrival) mod 4096. When `relMode` is 0, it is the absolute code. The other two fields are absolute in both cases.
- R8: `bubbleErr` bit m (0 arrival, 1 over-threshold, 2 calibration) is 1 when the break count of that record is not exactly one. The code is still formed from the lowest break, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| done | input | 1 | One-cycle strobe: snapshots on `snapIn` are stable |
| relMode | input | 1 | 1: over-threshold reported relative to arrival |
| snapIn | input | 111 | Three 37-bit raw records {cal, tot, arr} |
| rawWord | output | 111 | Captured raw records |
| codeWord | output | 36 | Encoded word {cal, tot, arr} |
| bubbleErr | output | 3 | Per-measurement bubble flags |
| wordValid | output | 1 | One-cycle strobe marking a new output word |

## Verification
The bench builds the block with its default parameters: 15 stages, 11-bit counters and 12-bit codes. These defaults make all 30 fine states reachable, along with both counter-choice boundaries (7/8 and 22/23) and codes that wrap past 4095. Random events skew the counter that should be ignored by up to ±1, which shows whether the wrong counter is ever read. Directed events cover the exact counter-choice boundaries, a relative result that goes negative, and snapshots with a flipped stage that create extra breaks.

// File: rtl/phaseEncPkg.sv
package phaseEncPkg;
  localparam int NUM_MEAS = 3;

  typedef struct packed {
    logic load;
  } encStrobes_t;
endpackage

// File: rtl/phaseDecoder.sv
module phaseDecoder #(
  parameter int STAGES = 15,
  parameter int CNT_W  = 11,
  parameter int CODE_W = 12
) (
  input  logic [STAGES+2*CNT_W-1:0] rec,
  output logic [CODE_W-1:0]         code,
  output logic                      bubble
);
  localparam int BINS  = 2 * STAGES;
  localparam int POS_W = $clog2(BINS);
  localparam int QTR   = STAGES / 2;

  logic [STAGES-1:0] phase;
  logic [STAGES-1:0] brk;
  logic [CNT_W-1:0]  riseCnt, fallCnt, coarse;
  logic [POS_W-1:0]  pos, fine;
  logic [POS_W-1:0]  nBrk;
  logic              upperHalf;

  assign phase   = rec[STAGES-1:0];
  assign riseCnt = rec[STAGES +: CNT_W];
  assign fallCnt = rec[STAGES+CNT_W +: CNT_W];

  // equal neighbours mark where the inverting pattern is broken
  assign brk[0] = phase[STAGES-1] ~^ phase[0];
  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : gBrk
      assign brk[g] = phase[g-1] ~^ phase[g];
    end
  endgenerate

  always_comb begin
    pos  = '0;
    nBrk = '0;
    for (int j = STAGES - 1; j >= 0; j--) begin
      if (brk[j]) pos = POS_W'(j);
    end
    for (int j = 0; j < STAGES; j++) begin
      nBrk = nBrk + POS_W'(brk[j]);
    end
  end

  assign bubble    = (nBrk != POS_W'(1));
  assign upperHalf = phase[0] ^ (pos != '0);
  assign fine      = upperHalf ? pos + POS_W'(STAGES) : pos;

  // read the counter whose edge is farthest from the latched phase
  always_comb begin
    if (fine >= POS_W'(QTR + 1) && fine <= POS_W'(STAGES + QTR))
      coarse = riseCnt - CNT_W'(1);
    else if (fine > POS_W'(STAGES + QTR))
      coarse = fallCnt - CNT_W'(1);
    else
      coarse = fallCnt;
  end

  assign code = CODE_W'(coarse) * CODE_W'(BINS) + CODE_W'(fine);
endmodule

// File: rtl/encControl.sv
module encControl
  import phaseEncPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        done,
  output encStrobes_t strobes,
  output logic        wordValid
);
  assign strobes.load = done;

  always_ff @(posedge clk) begin
    if (!rstN) wordValid <= 1'b0;
    else       wordValid <= done;
  end
endmodule

// File: rtl/encDatapath.sv
module encDatapath
  import phaseEncPkg::*;
#(
  parameter int STAGES = 15,
  parameter int CNT_W  = 11,
  parameter int CODE_W = 12
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  encStrobes_t                        strobes,
  input  logic                               relMode,
  input  logic [NUM_MEAS*(STAGES+2*CNT_W)-1:0] snapIn,
  output logic [NUM_MEAS*(STAGES+2*CNT_W)-1:0] rawWord,
  output logic [NUM_MEAS*CODE_W-1:0]          codeWord,
  output logic [NUM_MEAS-1:0]                 bubbleErr
);
  localparam int REC_W = STAGES + 2 * CNT_W;
  localparam int RAW_W = NUM_MEAS * REC_W;

  logic [CODE_W-1:0]        codes [NUM_MEAS];
  logic [NUM_MEAS-1:0]      bubbles;
  logic [CODE_W-1:0]        totField;
  logic [NUM_MEAS*CODE_W-1:0] codeNext;

  genvar m;
  generate
    for (m = 0; m < NUM_MEAS; m++) begin : gMeas
      phaseDecoder #(.STAGES(STAGES), .CNT_W(CNT_W), .CODE_W(CODE_W)) dec_i (
        .rec   (snapIn[m*REC_W +: REC_W]),
        .code  (codes[m]),
        .bubble(bubbles[m])
      );
    end
  endgenerate

  assign totField = relMode ? codes[1] - codes[0] : codes[1];
  assign codeNext = {codes[2], totField, codes[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawWord   <= '0;
      codeWord  <= '0;
      bubbleErr <= '0;
    end else if (strobes.load) begin
      rawWord   <= snapIn[RAW_W-1:0];
      codeWord  <= codeNext;
      bubbleErr <= bubbles;
    end
  end
endmodule

// File: rtl/phaseStampEncoder.sv
module phaseStampEncoder
  import phaseEncPkg::*;
#(
  parameter int STAGES = 15,
  parameter int CNT_W  = 11,
  parameter int CODE_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 done,
  input  logic                                 relMode,
  input  logic [NUM_MEAS*(STAGES+2*CNT_W)-1:0] snapIn,
  output logic [NUM_MEAS*(STAGES+2*CNT_W)-1:0] rawWord,
  output logic [NUM_MEAS*CODE_W-1:0]           codeWord,
  output logic [NUM_MEAS-1:0]                  bubbleErr,
  output logic                                 wordValid
);
  encStrobes_t strobes;

  encControl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .done     (done),
    .strobes  (strobes),
    .wordValid(wordValid)
  );

  encDatapath #(.STAGES(STAGES), .CNT_W(CNT_W), .CODE_W(CODE_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .relMode  (relMode),
    .snapIn   (snapIn),
    .rawWord  (rawWord),
    .codeWord (codeWord),
    .bubbleErr(bubbleErr)
  );
endmodule

// File: rtl/phaseStampEncoderChk.sv
module phaseStampEncoderChk #(
  parameter int RAW_W  = 111,
  parameter int CODE_BITS = 36,
  parameter int MEAS   = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 done,
  input logic [RAW_W-1:0]     snapIn,
  input logic [RAW_W-1:0]     rawWord,
  input logic [CODE_BITS-1:0] codeWord,
  input logic [MEAS-1:0]      bubbleErr,
  input logic                 wordValid
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (!wordValid && rawWord == '0)); // R1
  AST_RAW_CAPTURE: assert property (@(posedge clk) disable iff (!rstN) done |=> rawWord == $past(snapIn)); // R2
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN) done |=> wordValid); // R3
  AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN) !done |=> !wordValid); // R3
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN) !done |=> $stable(codeWord)); // R3
  AST_BUBBLE_HELD: assert property (@(posedge clk) disable iff (!rstN) !done |=> $stable(bubbleErr)); // R8
endmodule

bind phaseStampEncoder phaseStampEncoderChk #(
  .RAW_W(phaseEncPkg::NUM_MEAS*(STAGES+2*CNT_W)),
  .CODE_BITS(phaseEncPkg::NUM_MEAS*CODE_W),
  .MEAS(phaseEncPkg::NUM_MEAS)
) chk_i (
  .clk(clk), .rstN(rstN), .done(done), .snapIn(snapIn), .rawWord(rawWord),
  .codeWord(codeWord), .bubbleErr(bubbleErr), .wordValid(wordValid)
);

// File: tb/phaseStampEncoder_tb_top.sv
module phaseStampEncoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         done = 1'b0;
  logic         relMode = 1'b0;
  logic [110:0] snapIn = '0;
  logic [110:0] rawWord;
  logic [35:0]  codeWord;
  logic [2:0]   bubbleErr;
  logic         wordValid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phaseStampEncoder dut_i (
    .clk(clk), .rstN(rstN), .done(done), .relMode(relMode), .snapIn(snapIn),
    .rawWord(rawWord), .codeWord(codeWord), .bubbleErr(bubbleErr), .wordValid(wordValid)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clean record at time t (in bins); the counter the encoder must ignore is skewed
  function automatic logic [36:0] mkRec(int t, int skew);
    int n = t / 30;
    int k = t % 30;
    logic half = (k >= 15);
    int mm = half ? k - 15 : k;
    logic [14:0] p;
    int rise = n + ((k >= 1) ? 1 : 0);
    int fall = n + ((k >= 16) ? 1 : 0);
    for (int i = 0; i < 15; i++) p[i] = logic'(i % 2) ^ half ^ logic'(i < mm);
    if (k >= 8 && k <= 22) fall += skew; else rise += skew;
    return {11'(fall), 11'(rise), p};
  endfunction

  // expected code for any record, per the requirement text (used for bubble cases)
  function automatic logic [11:0] specCode(logic [36:0] r, output logic bub);
    int cnt = 0;
    int low = -1;
    int f, c;
    for (int j = 0; j < 15; j++) begin
      logic e = (j == 0) ? (r[14] == r[0]) : (r[j-1] == r[j]);
      if (e) begin cnt++; if (low < 0) low = j; end
    end
    if (low < 0) low = 0;
    bub = (cnt != 1);
    f = ((r[0] ^ (low != 0)) != 1'b0) ? low + 15 : low;
    if (f >= 8 && f <= 22) c = int'(r[25:15]) - 1;
    else if (f >= 23)      c = int'(r[36:26]) - 1;
    else                   c = int'(r[36:26]);
    return 12'((c & 11'h7ff) * 30 + f);
  endfunction

  task automatic runEvent(string req, logic [36:0] ra, logic [36:0] rt, logic [36:0] rc,
                          logic rel, logic [35:0] expCode, logic [2:0] expBub);
    logic [110:0] s = {rc, rt, ra};
    @(negedge clk);
    snapIn = s; relMode = rel; done = 1'b1;
    @(negedge clk);
    done = 1'b0; snapIn = ~s; relMode = ~rel;
    check({req, " R3 valid"}, 128'(wordValid), 128'(1));
    check({req, " R2 raw"}, 128'(rawWord), 128'(s));
    check({req, " R6 code"}, 128'(codeWord), 128'(expCode));
    check({req, " R8 bubble"}, 128'(bubbleErr), 128'(expBub));
    @(negedge clk);
    check({req, " R3 pulse"}, 128'(wordValid), 128'(0));
    check({req, " R3 hold"}, 128'(codeWord), 128'(expCode));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic b0, b1, b2;
    logic [36:0] ra, rt, rc;
    logic [11:0] ca, ct, cc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 128'(wordValid), 128'(0));
    check("R1 code in reset", 128'(codeWord), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 raw after reset", 128'(rawWord), 128'(0));
    check("R1 bubble after reset", 128'(bubbleErr), 128'(0));
    check("R1 valid after reset", 128'(wordValid), 128'(0));

    // R4/R5: every fine state and both counter-choice boundaries, with wrong counter skewed
    for (int k = 0; k < 30; k++) begin
      int t = 30 * 7 + k;
      runEvent("R4 R5 fine sweep", mkRec(t, 1), mkRec(t + 3, -1), mkRec(100, 0), 1'b0,
               {12'(100), 12'(t + 3), 12'(t)}, 3'b000);
    end

    // R6: code wraps modulo 4096
    runEvent("R6 wrap", mkRec(4095, 1), mkRec(4096, -1), mkRec(4200, 1), 1'b0,
             {12'(4200), 12'(4096), 12'(4095)}, 3'b000);

    // R7: relative over-threshold, including a negative difference
    runEvent("R7 relative", mkRec(1000, 1), mkRec(2500, 1), mkRec(50, -1), 1'b1,
             {12'(50), 12'(1500), 12'(1000)}, 3'b000);
    runEvent("R7 negative", mkRec(2000, -1), mkRec(1990, 1), mkRec(60, 1), 1'b1,
             {12'(60), 12'(-10), 12'(2000)}, 3'b000);

    // R8: bubbles from a flipped stage
    ra = mkRec(30 * 5 + 0, 0);  ra[5] = ~ra[5];
    rt = mkRec(30 * 9 + 10, 0); rt[3] = ~rt[3];
    rc = mkRec(30 * 2 + 20, 0);
    ca = specCode(ra, b0); ct = specCode(rt, b1); cc = specCode(rc, b2);
    check("R8 spec arr", 128'(ca), 128'(150));
    check("R8 spec tot", 128'(ct), 128'(273));
    runEvent("R8 bubble", ra, rt, rc, 1'b0, {cc, ct, ca}, {b2, b1, b0});

    // random events across all three records
    for (int e = 0; e < 300; e++) begin
      int ta = int'($urandom_range(58000, 0));
      int tt = ta + int'($urandom_range(1730, 2));
      int tc = int'($urandom_range(60000, 0));
      logic rel = logic'($urandom_range(1, 0));
      logic [11:0] tf = rel ? 12'(tt - ta) : 12'(tt);
      runEvent("R5 R6 R7 random",
               mkRec(ta, int'($urandom_range(2, 0)) - 1),
               mkRec(tt, int'($urandom_range(2, 0)) - 1),
               mkRec(tc, int'($urandom_range(2, 0)) - 1),
               rel, {12'(tc), tf, 12'(ta)}, 3'b000);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule